// File: doc/BRIEF.md
# Periodic Timeout Table Scanner

This engine runs once per time-base tick to age a table of 16-bit timeout counters that sit in memory at a fixed word stride. A counter value of zero marks an idle slot. Any other value is a live timer counting up toward zero, and the wrap to zero is its expiry. After a start strobe, the engine walks the table through a single-port synchronous memory. For each slot it reads the word, adds one, and stores the result back unless the slot was idle.

The walk stops at the first counter that expires or when the entry count runs out, whichever comes first. When it stops, the engine leaves behind the final pointer, the remaining count and a flag. The flag tells a clean pass ("no timeout") apart from a stop on an expired entry ("timeout"). After a timeout, the pointer still addresses the expired slot, so the caller can service that slot and then restart the scan from there. Deciding when to tick and what to do with an expired slot are left to the surrounding logic.

Top module: `tmo_scan_top`

## Requirements
- R1: A `start` pulse sampled while idle loads `base_addr` into the pointer and `entry_cnt` into the remaining count, and begins a scan. A `start` pulse sampled while `busy` is high has no effect on the scan or on its results.
- R2: Every visited word is read and incremented modulo 2^16. If the incremented value is 1, the slot was idle and no write is issued, so the memory word stays 0.
- R3: Any other incremented value is written back to the address it was read from. The write happens in the cycle right after the read cycle.
- R4: When the incremented value is 0, the scan ends at once. The pointer stays on the expired entry, the count is not decremented, and `no_timeout` is 0.
- R5: When the incremented value is not 0, the pointer advances by STRIDE (default 15) words and the count decrements by 1. Both are 16-bit registers and wrap modulo 2^16.
- R6: The scan continues while the count is above zero and no entry has expired. A scan that ends because the count reached zero reports `no_timeout` = 1.
- R7: A start with `entry_cnt` = 0 visits exactly one entry. If that entry does not expire, the count wraps to 16'hFFFF and `no_timeout` = 1. If it does expire, the count stays 0 and `no_timeout` = 0.
- R8: Reset leaves the engine idle with `busy` = 0, `done` = 0, `no_timeout` = 0, `addr_out` = 0, `cnt_out` = 0 and no memory request. `done` is a one-cycle pulse at the end of each scan. The results stay stable until the next accepted start.
- R9: Each visited entry takes exactly two cycles, one read cycle and one evaluate/write cycle. For a scan of n entries, `done` rises 2n cycles after the edge that accepts `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan (accepted only while idle) |
| base_addr | input | 16 | Address of the first counter |
| entry_cnt | input | 16 | Number of entries to visit |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write enable (1 = write, 0 = read) |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| no_timeout | output | 1 | 1 = table exhausted, 0 = stopped on an expired entry |
| addr_out | output | 16 | Final pointer |
| cnt_out | output | 16 | Final remaining count |

## Verification
The bench targets several corner cases, and each one exposes a specific kind of faulty design:
- Idle slots: a design that writes back unconditionally turns them into 1.
- An expiry on the first entry, in the middle of the table, or on the last entry: a design that advances before checking expiry leaves the pointer one stride too far, or decrements the count.
- A zero entry count: a design that tests the count before the first visit does nothing, and one that trusts only the wrapped count walks 65535 more entries.
- A table that crosses the top of the address space: this exposes a pointer that saturates or is narrower than 16 bits.
- A second start issued during a scan: a design that accepts it restarts at the wrong base.

// File: rtl/tmo_pkg.sv
package tmo_pkg;

    localparam int WORD_W = 16;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_EVAL = 2'd2
    } scan_state_e;

    typedef struct packed {
        scan_state_e state;
        word_t       ptr;
        word_t       remain;
        logic        single;
        logic        done;
        logic        no_tmo;
    } scan_regs_t;

endpackage

// File: rtl/tmo_step.sv
module tmo_step
    import tmo_pkg::*;
(
    input  word_t rd_word,
    output word_t bumped,
    output logic  wr_needed,
    output logic  expired
);
    localparam word_t ONE  = word_t'(1);
    localparam word_t ZERO = '0;

    always_comb begin
        bumped    = rd_word + ONE;
        wr_needed = (bumped != ONE);
        expired   = (bumped == ZERO);
    end
endmodule

// File: rtl/tmo_advance.sv
module tmo_advance
    import tmo_pkg::*;
#(
    parameter int STRIDE = 15
) (
    input  word_t ptr,
    input  word_t remain,
    input  logic  single,
    input  logic  expired,
    output word_t ptr_nx,
    output word_t remain_nx,
    output logic  last
);
    localparam word_t STEP = word_t'(STRIDE);
    localparam word_t ONE  = word_t'(1);

    always_comb begin
        if (expired) begin
            ptr_nx    = ptr;
            remain_nx = remain;
            last      = 1'b1;
        end else begin
            ptr_nx    = ptr + STEP;
            remain_nx = remain - ONE;
            last      = single || (remain_nx == '0);
        end
    end
endmodule

// File: rtl/tmo_scan_top.sv
module tmo_scan_top
    import tmo_pkg::*;
#(
    parameter int STRIDE = 15
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [15:0] base_addr,
    input  logic [15:0] entry_cnt,
    output logic        mem_req,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    input  logic [15:0] mem_rdata,
    output logic        busy,
    output logic        done,
    output logic        no_timeout,
    output logic [15:0] addr_out,
    output logic [15:0] cnt_out
);
    scan_regs_t q, d;

    word_t bumped, ptr_nx, remain_nx;
    logic  wr_needed, expired, last;

    tmo_step u_step (
        .rd_word  (mem_rdata),
        .bumped   (bumped),
        .wr_needed(wr_needed),
        .expired  (expired)
    );

    tmo_advance #(.STRIDE(STRIDE)) u_adv (
        .ptr      (q.ptr),
        .remain   (q.remain),
        .single   (q.single),
        .expired  (expired),
        .ptr_nx   (ptr_nx),
        .remain_nx(remain_nx),
        .last     (last)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.ptr;
        mem_wdata = '0;
        unique case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.ptr    = base_addr;
                    d.remain = entry_cnt;
                    d.single = (entry_cnt == '0);
                    d.no_tmo = 1'b0;
                    d.state  = ST_READ;
                end
            end
            ST_READ: begin
                mem_req = 1'b1;
                d.state = ST_EVAL;
            end
            ST_EVAL: begin
                if (wr_needed) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_wdata = bumped;
                end
                d.ptr    = ptr_nx;
                d.remain = remain_nx;
                if (last) begin
                    d.state  = ST_IDLE;
                    d.done   = 1'b1;
                    d.no_tmo = !expired;
                end else begin
                    d.state = ST_READ;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, ptr: '0, remain: '0,
                   single: 1'b0, done: 1'b0, no_tmo: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign busy       = (q.state != ST_IDLE);
    assign done       = q.done;
    assign no_timeout = q.no_tmo;
    assign addr_out   = q.ptr;
    assign cnt_out    = q.remain;
endmodule

// File: rtl/tmo_scan_chk.sv
module tmo_scan_chk #(
    parameter int STRIDE = 15
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic        mem_we,
    input logic [15:0] mem_addr,
    input logic [15:0] mem_wdata,
    input logic        busy,
    input logic        done
);
    logic [15:0] prev_rd;
    logic        in_scan;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_rd <= '0;
            in_scan <= 1'b0;
        end else if (done) begin
            in_scan <= 1'b0;
        end else if (mem_req && !mem_we) begin
            prev_rd <= mem_addr;
            in_scan <= 1'b1;
        end
    end

    // R2: an idle slot never has 1 written into it
    a_r2_no_idle_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_wdata != 16'h0001));

    // R3: a write follows a read of the same address
    a_r3_write_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ($past(mem_req && !mem_we) && mem_addr == $past(mem_addr)));

    // R5: consecutive reads within one scan are STRIDE words apart
    a_r5_stride: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && in_scan) |-> (mem_addr == 16'(prev_rd + 16'(STRIDE))));

    // R8: done lasts one cycle and the engine is idle while it is shown
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R9: a read is always followed by an evaluate cycle that does not read
    a_r9_two_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> (busy && !(mem_req && !mem_we)) || done);
endmodule

bind tmo_scan_top tmo_scan_chk #(.STRIDE(STRIDE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .busy     (busy),
    .done     (done)
);

// File: tb/sim_tmo_scan_top.sv
module sim_tmo_scan_top;
    localparam int STRIDE = 15;
    localparam int MW = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] base_addr = '0;
    logic [15:0] entry_cnt = '0;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        busy, done, no_timeout;
    logic [15:0] addr_out, cnt_out;

    logic        poke_en = 1'b0;
    logic [9:0]  poke_addr = '0;
    logic [15:0] poke_data = '0;

    logic [15:0] mem [MW];
    logic [15:0] shadow [MW];

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    tmo_scan_top #(.STRIDE(STRIDE)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .base_addr(base_addr), .entry_cnt(entry_cnt),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .no_timeout(no_timeout),
        .addr_out(addr_out), .cnt_out(cnt_out)
    );

    always_ff @(posedge clk) begin
        if (poke_en) mem[poke_addr] <= poke_data;
        else if (mem_req && mem_we) mem[mem_addr[9:0]] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[9:0]];
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [15:0] a, input logic [15:0] v);
        poke_en = 1'b1; poke_addr = a[9:0]; poke_data = v;
        shadow[a[9:0]] = v;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic ref_scan(input logic [15:0] b, input logic [15:0] c,
                            output logic [15:0] ea, output logic [15:0] ec,
                            output logic ef, output int it);
        logic [15:0] v;
        logic single;
        bit stop;
        ea = b; ec = c; single = (c == 0); it = 0; stop = 0; ef = 1'b1;
        while (!stop) begin
            it++;
            v = shadow[ea[9:0]] + 16'd1;
            if (v != 16'd1) shadow[ea[9:0]] = v;
            if (v == 16'd0) begin
                ef = 1'b0; stop = 1;
            end else begin
                ea = ea + 16'(STRIDE);
                ec = ec - 16'd1;
                if (single || ec == 0) stop = 1;
            end
        end
    endtask

    task automatic check_mem(input string tag);
        int bad = 0;
        for (int i = 0; i < MW; i++) if (mem[i] !== shadow[i]) bad++;
        check({tag, " memory image"}, 16'(bad), 16'd0);
    endtask

    // Runs one scan; if interfere is set, a second start is pulsed mid-scan (R1)
    task automatic run_scan(input string tag, input logic [15:0] b, input logic [15:0] c,
                            input bit interfere);
        logic [15:0] ea, ec;
        logic ef;
        int it, cyc;
        ref_scan(b, c, ea, ec, ef, it);
        base_addr = b; entry_cnt = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (interfere && cyc == 1) begin
                start = 1'b1; base_addr = 16'd900; entry_cnt = 16'd1;
            end else begin
                start = 1'b0;
            end
        end
        if (cyc >= 5000) begin
            n_chk++; n_bad++;
            $display("FAIL %s R9: watchdog, actual no done expected done", tag);
        end
        check({tag, " R9 cycles"}, 16'(cyc), 16'(2 * it));
        check({tag, " R4/R5 addr_out"}, addr_out, ea);
        check({tag, " R4/R5 cnt_out"}, cnt_out, ec);
        check({tag, " R6 no_timeout"}, 16'(no_timeout), 16'(ef));
        @(negedge clk);
        check({tag, " R8 done one cycle"}, 16'(done), 16'd0);
        check({tag, " R8 results held"}, addr_out, ea);
        check_mem(tag);
    endtask

    task automatic t_reset;
        check("R8 reset busy", 16'(busy), 16'd0);
        check("R8 reset done", 16'(done), 16'd0);
        check("R8 reset flag", 16'(no_timeout), 16'd0);
        check("R8 reset addr", addr_out, 16'd0);
        check("R8 reset cnt", cnt_out, 16'd0);
        check("R8 reset req", 16'(mem_req), 16'd0);
    endtask

    task automatic t_idle_slots;   // R2: all idle, nothing written
        run_scan("R2 idle table", 16'd16, 16'd4, 1'b0);
    endtask

    task automatic t_active;       // R3 R5 R6
        poke(16'd100, 16'hFFF0);
        poke(16'd115, 16'd0);
        poke(16'd130, 16'd5);
        poke(16'd145, 16'h8000);
        poke(16'd160, 16'h7FFF);
        run_scan("R3 active mix", 16'd100, 16'd5, 1'b0);
    endtask

    task automatic t_expire_mid;   // R4
        poke(16'd300, 16'd3);
        poke(16'd330, 16'hFFFF);
        poke(16'd360, 16'd7);
        run_scan("R4 expire mid", 16'd300, 16'd6, 1'b0);
        check("R4 later entry untouched", mem[360], 16'd7);
    endtask

    task automatic t_expire_edges; // R4 first and last entry
        poke(16'd400, 16'hFFFF);
        run_scan("R4 expire first", 16'd400, 16'd3, 1'b0);
        poke(16'd430, 16'd2);
        poke(16'd445, 16'hFFFF);
        run_scan("R4 expire last", 16'd430, 16'd2, 1'b0);
    endtask

    task automatic t_zero_count;   // R7
        poke(16'd500, 16'd9);
        poke(16'd515, 16'd9);
        run_scan("R7 zero count", 16'd500, 16'd0, 1'b0);
        check("R7 neighbour untouched", mem[515], 16'd9);
        poke(16'd550, 16'hFFFF);
        run_scan("R7 zero count expire", 16'd550, 16'd0, 1'b0);
    endtask

    task automatic t_wrap;         // R5 pointer wrap
        poke(16'hFFF8, 16'd1);
        poke(16'h0007, 16'd2);
        run_scan("R5 addr wrap", 16'hFFF8, 16'd2, 1'b0);
    endtask

    task automatic t_ignore_start; // R1
        poke(16'd600, 16'd4);
        poke(16'd615, 16'd4);
        poke(16'd630, 16'd4);
        poke(16'd900, 16'd50);
        run_scan("R1 start while busy", 16'd600, 16'd3, 1'b1);
        check("R1 other base untouched", mem[900], 16'd50);
    endtask

    initial begin
        for (int i = 0; i < MW; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        for (int i = 0; i < MW; i++) poke(16'(i), 16'd0);
        t_idle_slots();
        t_active();
        t_expire_mid();
        t_expire_edges();
        t_zero_count();
        t_wrap();
        t_ignore_start();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL R9: global watchdog, actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule